// File: doc/BRIEF.md
# Digitally Trimmed Seconds Prescaler

This block turns a 32,768 Hz oscillator tick (one enable pulse per oscillator cycle) into a once-per-second strobe. Crystal error is corrected digitally rather than with trim capacitors. The block adjusts the count at the divide-by-256 point of the chain. The seconds that are adjusted are picked from a 64-minute cycle, according to a 6-bit calibration word.

A positive calibration makes the clock run faster: each chosen second ends 256 oscillator cycles early. A negative calibration makes it run slower: each chosen second runs 128 cycles long. A magnitude of N adjusts the first second of each of the first 2N minutes of the cycle, so one step is worth +512 or −256 oscillator cycles per 64 minutes. The block also marks the last second of each minute.

The block drives a 512 Hz square wave for production frequency measurement. This wave comes from the divider and is not touched by the correction. It is gated so that it appears only when the test bit is set and the shared pin is not claimed by the alarm interrupt or by a watchdog interrupt. A stop input freezes the divider while the oscillator is shut down.

Top module: `trim_prescaler`

## Requirements
- R1: When a second is not corrected, it lasts 2^(PRE_W+SUB_W) ticks (32,768 by default). `sec_o` is a one-cycle pulse in the clock cycle after the tick that completes the second.
- R2: `min_o` pulses together with `sec_o` for the last second of each minute, and at no other time. Seconds count 0..SEC_PER_MIN-1 and minutes count 0..63, then wrap to 0.
- R3: Only second 0 of minute m is corrected, and only when m < 2·mag, where mag = `cal_i[4:0]`. With mag 0 no second is corrected. With mag 31 minutes 0..61 are corrected and minutes 62 and 63 are not.
- R4: With `cal_i[5]` = 1 (positive), a corrected second lasts 256 ticks less than nominal.
- R5: With `cal_i[5]` = 0 (negative), a corrected second lasts 128 ticks more than nominal.
- R6: When enabled, `ftest_o` is low for ticks 0..31 and high for ticks 32..63 of every 64-tick window, counted from the start of the current second. This gives 512 Hz, whatever the calibration word.
- R7: `ftest_o` is high only if all of these hold: `stop_i`=0, `ftest_bit_i`=1, `alarm_irq_en_i`=0, and (`wd_steer_rst_i`=1 or `wd_idle_i`=1). Otherwise it is 0.
- R8: While `stop_i` is 1, no `sec_o` is produced and the divider returns to zero. The minute position is kept. After release, the next `sec_o` comes after one full second (nominal or corrected) of ticks counted from the release.
- R9: A cycle with `tick_en_i`=0 advances nothing. `sec_o` stays low and `ftest_o` holds its value.
- R10: During reset `sec_o`, `min_o` and `ftest_o` are 0, and the divider and the position start from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | One pulse per oscillator cycle |
| cal_i | input | 6 | [5] sign (1 = faster), [4:0] magnitude |
| stop_i | input | 1 | Oscillator stop: freezes and clears the divider |
| ftest_bit_i | input | 1 | Frequency test request |
| alarm_irq_en_i | input | 1 | Alarm interrupt owns the pin |
| wd_steer_rst_i | input | 1 | Watchdog steered to reset instead of the pin |
| wd_idle_i | input | 1 | Watchdog timeout word is zero |
| sec_o | output | 1 | Seconds strobe |
| min_o | output | 1 | Last second of minute strobe |
| ftest_o | output | 1 | Gated 512 Hz test wave |

## Verification
A corrected second and the test wave's 64-tick phase can coincide. The second is then cut short or stretched while the 512 Hz wave must run on without a glitch. The bench provokes this by picking calibration magnitudes at and around each minute's 2·mag boundary, while tick gaps and enable patterns are random. Each second's length is judged in ticks against the bench's own model, and the test wave is compared on every cycle against the tick count since that second began.

// File: rtl/trim_prescaler_pkg.sv
package trim_prescaler_pkg;
  localparam int MAG_W = 5;
  localparam int CAL_W = MAG_W + 1;

  typedef struct packed {
    logic             positive;
    logic [MAG_W-1:0] mag;
  } trim_cal_t;

  // test wave may drive the shared pin only when nobody else claims it
  function automatic logic ftest_allowed(logic stop, logic ft_bit, logic alarm_en,
                                         logic wd_steer_rst, logic wd_idle);
    return !stop && ft_bit && !alarm_en && (wd_steer_rst || wd_idle);
  endfunction
endpackage

// File: rtl/trim_div_stage.sv
module trim_div_stage #(
  parameter int PRE_W = 8,
  parameter int SUB_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_en_i,
  input  logic stop_i,
  input  logic corr_i,
  input  logic positive_i,
  output logic sec_end_o,
  output logic phase_o
);
  localparam int CW    = PRE_W + 1;
  localparam int STAGE = 1 << PRE_W;
  localparam int FT_B  = PRE_W - 3;
  localparam logic [CW-1:0] TERM_NORM = CW'(STAGE - 1);
  localparam logic [CW-1:0] TERM_LONG = CW'(STAGE + STAGE / 2 - 1);

  logic [CW-1:0]    pre_q, term;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W:0]   sub_sum;
  logic             first, stretch, split, stage_wrap;

  always_comb begin
    first      = (sub_q == '0);
    stretch    = corr_i && !positive_i && first;
    split      = corr_i && positive_i && first;
    term       = stretch ? TERM_LONG : TERM_NORM;
    stage_wrap = tick_en_i && !stop_i && (pre_q >= term);
    sub_sum    = {1'b0, sub_q} + (split ? (SUB_W+1)'(2) : (SUB_W+1)'(1));
    sec_end_o  = stage_wrap && sub_sum[SUB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (stop_i) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (tick_en_i) begin
      if (pre_q >= term) begin
        pre_q <= '0;
        sub_q <= sec_end_o ? '0 : sub_sum[SUB_W-1:0];
      end else begin
        pre_q <= pre_q + CW'(1);
      end
    end
  end

  // stage lengths are multiples of 64, so this bit stays a clean 512 Hz
  assign phase_o = pre_q[FT_B];

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !stop_i) |=> ($stable(pre_q) && $stable(sub_q)));
  p_stop_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (pre_q == '0 && sub_q == '0));
  p_pre_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= TERM_LONG);
endmodule

// File: rtl/trim_position.sv
module trim_position #(
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64,
  parameter int MAG_W       = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sec_end_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             corr_o,
  output logic             sec_o,
  output logic             min_o
);
  localparam int SEC_W = $clog2(SEC_PER_MIN);
  localparam int MIN_W = $clog2(CYCLE_MIN);

  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [MIN_W:0]   span;
  logic             last_sec;

  always_comb begin
    last_sec = (sec_q == SEC_W'(SEC_PER_MIN - 1));
    span     = (MIN_W+1)'({mag_i, 1'b0});
    corr_o   = (sec_q == '0) && ({1'b0, min_q} < span);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= '0;
      min_q <= '0;
      sec_o <= 1'b0;
      min_o <= 1'b0;
    end else begin
      sec_o <= sec_end_i;
      min_o <= sec_end_i && last_sec;
      if (sec_end_i) begin
        if (last_sec) begin
          sec_q <= '0;
          min_q <= (min_q == MIN_W'(CYCLE_MIN - 1)) ? '0 : min_q + MIN_W'(1);
        end else begin
          sec_q <= sec_q + SEC_W'(1);
        end
      end
    end
  end

  p_sec_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_o |=> !sec_o);
  p_min_with_sec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    min_o |-> sec_o);
endmodule

// File: rtl/trim_ftest_gate.sv
module trim_ftest_gate
  import trim_prescaler_pkg::*;
(
  input  logic stop_i,
  input  logic ft_bit_i,
  input  logic alarm_en_i,
  input  logic wd_steer_rst_i,
  input  logic wd_idle_i,
  input  logic phase_i,
  output logic ftest_o
);
  always_comb
    ftest_o = phase_i && ftest_allowed(stop_i, ft_bit_i, alarm_en_i, wd_steer_rst_i, wd_idle_i);
endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler
  import trim_prescaler_pkg::*;
#(
  parameter int PRE_W       = 8,
  parameter int SUB_W       = 7,
  parameter int SEC_PER_MIN = 60,
  parameter int CYCLE_MIN   = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_en_i,
  input  logic [CAL_W-1:0] cal_i,
  input  logic             stop_i,
  input  logic             ftest_bit_i,
  input  logic             alarm_irq_en_i,
  input  logic             wd_steer_rst_i,
  input  logic             wd_idle_i,
  output logic             sec_o,
  output logic             min_o,
  output logic             ftest_o
);
  trim_cal_t cal;
  logic      corr, sec_end, phase;

  assign cal = trim_cal_t'(cal_i);

  trim_div_stage #(.PRE_W(PRE_W), .SUB_W(SUB_W)) i_div (
    .clk_i, .rst_ni, .tick_en_i, .stop_i,
    .corr_i(corr), .positive_i(cal.positive),
    .sec_end_o(sec_end), .phase_o(phase)
  );

  trim_position #(.SEC_PER_MIN(SEC_PER_MIN), .CYCLE_MIN(CYCLE_MIN), .MAG_W(MAG_W)) i_pos (
    .clk_i, .rst_ni, .sec_end_i(sec_end), .mag_i(cal.mag),
    .corr_o(corr), .sec_o, .min_o
  );

  trim_ftest_gate i_ftg (
    .stop_i, .ft_bit_i(ftest_bit_i), .alarm_en_i(alarm_irq_en_i),
    .wd_steer_rst_i, .wd_idle_i, .phase_i(phase), .ftest_o
  );

  p_ftest_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !ftest_o);
  p_ftest_alarm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_irq_en_i |-> !ftest_o);
endmodule

// File: tb/test_trim_prescaler.sv
module test_trim_prescaler;
  import trim_prescaler_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W      = 8;
  localparam int SUB_W      = 1;
  localparam int SPM        = 2;
  localparam int CYC        = 64;
  localparam int BASE       = 1 << (PRE_W + SUB_W);
  localparam int N_SECS     = 140;
  localparam int WD_LIMIT   = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0, tick_en_i = 1'b0, stop_i = 1'b0;
  logic ftest_bit_i = 1'b0, alarm_irq_en_i = 1'b0, wd_steer_rst_i = 1'b0, wd_idle_i = 1'b0;
  logic [CAL_W-1:0] cal_i = '0;
  logic sec_o, min_o, ftest_o;

  int errors = 0, checks = 0, cyc = 0;
  int m_sec = 0, m_min = 0, tick_count = 0, secs_seen = 0;
  bit done = 0, post_stop = 0, stop_done = 0, gap_done = 0, en_exp = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  trim_prescaler #(.PRE_W(PRE_W), .SUB_W(SUB_W), .SEC_PER_MIN(SPM), .CYCLE_MIN(CYC)) i_trim_prescaler (
    .clk_i, .rst_ni, .tick_en_i, .cal_i, .stop_i, .ftest_bit_i, .alarm_irq_en_i,
    .wd_steer_rst_i, .wd_idle_i, .sec_o, .min_o, .ftest_o
  );

  function automatic int exp_len(int s, int m, logic [CAL_W-1:0] c);
    int mag = int'(c[MAG_W-1:0]);
    if (s == 0 && m < 2 * mag) return c[MAG_W] ? BASE - 256 : BASE + 128;
    return BASE;
  endfunction

  function automatic string len_tag(int s, int m, logic [CAL_W-1:0] c, bit after_stop);
    if (after_stop) return "R8";
    if (s == 0 && m < 2 * int'(c[MAG_W-1:0])) return c[MAG_W] ? "R4" : "R5";
    if (s == 0) return "R3";
    return "R1";
  endfunction

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (sec=%0d min=%0d)", tag, act, exp, m_sec, m_min);
    end
  endtask

  // calibration chosen around the 2*mag boundary of the coming minute
  task automatic pick_inputs();
    int mag;
    bit pos;
    pos = 1'($urandom % 2);
    if (m_sec == 0) begin
      case ($urandom % 4)
        0: mag = m_min / 2;
        1: mag = m_min / 2 + 1;
        2: mag = 0;
        default: mag = int'($urandom % 32);
      endcase
    end else mag = int'($urandom % 32);
    if (mag > 31) mag = 31;
    cal_i          = {pos, MAG_W'(mag)};
    ftest_bit_i    = ($urandom % 4) != 0;
    alarm_irq_en_i = ($urandom % 4) == 0;
    wd_steer_rst_i = 1'($urandom % 2);
    wd_idle_i      = 1'($urandom % 2);
    en_exp = ftest_bit_i && !alarm_irq_en_i && (wd_steer_rst_i || wd_idle_i);
  endtask

  task automatic run_stop();
    stop_i = 1'b1;
    tick_en_i = 1'($urandom % 2);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      chk(sec_o == 1'b0, "R8", sec_o, 0);
      chk(ftest_o == 1'b0, "R7", ftest_o, 0);
      tick_en_i = 1'($urandom % 2);
    end
    stop_i = 1'b0;
    tick_en_i = 1'b0;
    tick_count = 0;
    post_stop = 1;
  endtask

  task automatic run_gap();
    logic ref_ft;
    tick_en_i = 1'b0;
    ref_ft = ftest_o;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      chk(sec_o == 1'b0, "R9", sec_o, 0);
      chk(ftest_o == ref_ft, "R9", ftest_o, ref_ft);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > WD_LIMIT && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL R1: watchdog expired actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
      report();
    end
  end

  initial begin
    int exp_ft;
    int el;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    chk(sec_o == 1'b0, "R10", sec_o, 0);
    chk(min_o == 1'b0, "R10", min_o, 0);
    chk(ftest_o == 1'b0, "R10", ftest_o, 0);
    pick_inputs();
    rst_ni = 1'b1;
    while (secs_seen < N_SECS) begin
      @(negedge clk_i);
      exp_ft = (en_exp && ((sec_o ? 0 : tick_count) % 64) >= 32) ? 1 : 0;
      chk(ftest_o == 1'(exp_ft), en_exp ? "R6" : "R7", ftest_o, exp_ft);
      if (sec_o) begin
        el = exp_len(m_sec, m_min, cal_i);
        chk(tick_count == el, len_tag(m_sec, m_min, cal_i, post_stop), tick_count, el);
        chk(min_o == (m_sec == SPM - 1), "R2", min_o, (m_sec == SPM - 1) ? 1 : 0);
        if (m_sec == SPM - 1) begin
          m_sec = 0;
          m_min = (m_min == CYC - 1) ? 0 : m_min + 1;
        end else m_sec++;
        tick_count = 0;
        secs_seen++;
        post_stop = 0;
        pick_inputs();
      end else begin
        chk(min_o == 1'b0, "R2", min_o, 0);
      end
      if (secs_seen == 20 && tick_count == 100 && !stop_done) begin
        stop_done = 1;
        run_stop();
      end else if (secs_seen == 30 && tick_count == 50 && !gap_done) begin
        gap_done = 1;
        run_gap();
      end else begin
        tick_en_i = ($urandom % 8) != 0;
        if (tick_en_i) tick_count++;
      end
    end
    done = 1;
    report();
  end
endmodule